// File: doc/BRIEF.md
# Parallel FPGA Configuration Host Sequencer

This block runs on the host side and loads a slave FPGA that is configured over a passive parallel bus. It pulses the target's active-low program line, waits until the target is ready, and then clocks configuration words from an upstream valid/ready stream onto an 8- or 16-bit data bus. The block drives the configuration clock itself. It watches the target's active-low status line and its active-high configuration-complete line, and reports success or one of two error flags.

A target that decompresses or decrypts the bitstream needs each word held for several configuration clocks, so the block keeps each word on the bus for `RATIO` clock periods. It stalls the upstream stream through `in_ready` while it holds a word. Every pulse width and wait is a parameter counted in system-clock cycles. The defaults are derived from the system clock frequency in MHz.

After the final word the block keeps the configuration clock running until the target reports completion. It then gives `INIT_CLKS` further clocks so the target can initialise, and raises `done`. If completion never arrives, a timeout raises an error instead of leaving the block hung. A new configuration attempt, including a retry after an error, is started by pulsing `start` again.

Top module: `ppcfg_host`

## Requirements
- R1: After reset the program line is high, the configuration clock is low, `in_ready`, `busy`, `done`, `err_status` and `err_timeout` are all low.
- R2: A `start` pulse while not busy drives the program line low for exactly `PROG_LOW_CYC` system cycles. The configuration clock stays low during that pulse.
- R3: With `mon_status` high at start, the first rising edge of the configuration clock comes no earlier than `STAT2CLK_CYC` cycles after the status line returns high.
- R4: With `mon_status` low at start, the first rising edge comes no earlier than `PROG2CLK_CYC` cycles after the program line returns high.
- R5: Every high phase and every low phase of the configuration clock lasts at least `DCLK_HALF` system cycles. The clock frequency is therefore at most the system frequency divided by 2·`DCLK_HALF`.
- R6: Each accepted word is captured by exactly `RATIO` consecutive rising edges, in stream order. The data bus changes only while the configuration clock is low.
- R7: Exactly one handshake (`in_valid` and `in_ready` both high) occurs per word. `in_ready` is never high while the configuration clock is high.
- R8: After the word marked `in_last`, the clock keeps toggling until the completion line is seen high. Between `INIT_CLKS` and `INIT_CLKS`+2 further rising edges follow, then `done` rises, the clock stops low, and no error flag is set.
- R9: If completion is not seen within `CD_TIMEOUT_CLKS` clock periods after the last word, exactly that many extra rising edges are produced. After them `err_timeout` rises, `done` stays low, and the clock stops low with `busy` low.
- R10: With status monitoring, a low status line during loading, post-data or initialisation stops the clock at once (no further rising edge) and raises `err_status`.
- R11: Without status monitoring, a low status line during loading is ignored and the sequence completes with `done`.
- R12: `start` while busy has no effect on the running sequence. `start` after `done` or an error begins a new attempt and clears all flags.
- R13: With status monitoring, if the status line does not return high within `ST_TIMEOUT_CYC` cycles after the program pulse, `err_status` rises with no configuration clock edge produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration attempt (ignored while busy) |
| mon_status | input | 1 | Captured at start: 1 = gate on and watch the status line |
| in_data | input | DW | Upstream configuration word |
| in_valid | input | 1 | Upstream word valid |
| in_last | input | 1 | Marks the final word of the bitstream |
| in_ready | output | 1 | Block accepts a word this cycle |
| tgt_prog_n | output | 1 | Active-low program pulse to the target |
| tgt_clk | output | 1 | Configuration clock to the target |
| tgt_data | output | DW | Configuration data bus to the target |
| tgt_stat_n | input | 1 | Active-low status from the target |
| tgt_cfg_ok | input | 1 | Configuration-complete indication from the target |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last attempt finished successfully |
| err_status | output | 1 | Status line fault (never released or dropped mid-load) |
| err_timeout | output | 1 | Completion not seen within the timeout |

## Verification
The bench drives a behavioural target model and sweeps stream lengths from one to six words, with irregular gaps on `in_valid`. It runs both gating modes. If a design advanced the word after fewer than `RATIO` edges, or changed data during a high phase, the captured sequence would miscompare. If it opened the clock right after the program pulse, the measured gap to the first edge would fall short. The bench also targets three edge cases:
- A completion line that never rises. A miscounting timeout shows up as a wrong edge total.
- A status drop after the fifth edge. A design that missed it would keep clocking.
- A status line held low. A design without the release timeout would hang until the watchdog fires.

A restart pulse injected mid-load checks that a design which re-armed while busy would corrupt the word sequence.

// File: rtl/ppcfg_host.sv
`timescale 1ns/1ps
module ppcfg_host #(
  parameter int CLK_MHZ         = 50,
  parameter int DW              = 8,
  parameter int RATIO           = 4,
  parameter int DCLK_HALF       = 1,
  parameter int PROG_LOW_CYC    = 2 * CLK_MHZ,
  parameter int STAT2CLK_CYC    = 2 * CLK_MHZ,
  parameter int PROG2CLK_CYC    = 1506 * CLK_MHZ,
  parameter int ST_TIMEOUT_CYC  = 1506 * CLK_MHZ,
  parameter int CD_TIMEOUT_CLKS = 4096,
  parameter int INIT_CLKS       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mon_status,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          tgt_prog_n,
  output logic          tgt_clk,
  output logic [DW-1:0] tgt_data,
  input  logic          tgt_stat_n,
  input  logic          tgt_cfg_ok,
  output logic          busy,
  output logic          done,
  output logic          err_status,
  output logic          err_timeout
);

  localparam int BW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int HW = (DCLK_HALF > 1) ? $clog2(DCLK_HALF) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WAIT, S_LOAD, S_SHIFT, S_POST, S_INIT, S_DONE, S_FAIL
  } state_t;

  state_t        state;
  logic [1:0]    st_sync, ok_sync;
  logic [31:0]   tmr, aux;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] beat;
  logic          clk_q, last_q, mon_q, done_q, est_q, eto_q;
  logic [DW-1:0] data_q;

  wire st_s      = st_sync[1];
  wire ok_s      = ok_sync[1];
  wire toggling  = state inside {S_SHIFT, S_POST, S_INIT};
  wire half_end  = (hcnt == HW'(DCLK_HALF - 1));
  wire cyc_end   = toggling && clk_q && half_end;
  wire stat_lost = mon_q && !st_s && (state inside {S_LOAD, S_SHIFT, S_POST, S_INIT});
  wire start_ok  = start && (state inside {S_IDLE, S_DONE, S_FAIL});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_sync <= 2'b00;
      ok_sync <= 2'b00;
    end else begin
      st_sync <= {st_sync[0], tgt_stat_n};
      ok_sync <= {ok_sync[0], tgt_cfg_ok};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      tmr    <= '0;
      aux    <= '0;
      hcnt   <= '0;
      beat   <= '0;
      clk_q  <= 1'b0;
      last_q <= 1'b0;
      mon_q  <= 1'b0;
      done_q <= 1'b0;
      est_q  <= 1'b0;
      eto_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (toggling) begin
        if (half_end) begin
          hcnt  <= '0;
          clk_q <= ~clk_q;
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end

      if (start_ok) begin
        state  <= S_PROG;
        tmr    <= '0;
        aux    <= '0;
        hcnt   <= '0;
        clk_q  <= 1'b0;
        mon_q  <= mon_status;
        done_q <= 1'b0;
        est_q  <= 1'b0;
        eto_q  <= 1'b0;
      end else if (stat_lost) begin
        state <= S_FAIL;
        est_q <= 1'b1;
        clk_q <= 1'b0;
      end else begin
        case (state)
          S_PROG:
            if (tmr == 32'(PROG_LOW_CYC - 1)) begin
              state <= S_WAIT;
              tmr   <= '0;
            end else begin
              tmr <= tmr + 32'd1;
            end
          S_WAIT:
            if (mon_q) begin
              if (!st_s) begin
                tmr <= '0;
                if (aux == 32'(ST_TIMEOUT_CYC - 1)) begin
                  state <= S_FAIL;
                  est_q <= 1'b1;
                end else begin
                  aux <= aux + 32'd1;
                end
              end else if (tmr == 32'(STAT2CLK_CYC - 1)) begin
                state <= S_LOAD;
              end else begin
                tmr <= tmr + 32'd1;
              end
            end else if (tmr == 32'(PROG2CLK_CYC - 1)) begin
              state <= S_LOAD;
            end else begin
              tmr <= tmr + 32'd1;
            end
          S_LOAD:
            if (in_valid) begin
              data_q <= in_data;
              last_q <= in_last;
              beat   <= '0;
              hcnt   <= '0;
              state  <= S_SHIFT;
            end
          S_SHIFT:
            if (cyc_end) begin
              if (beat == BW'(RATIO - 1)) begin
                beat <= '0;
                if (last_q) begin
                  state <= S_POST;
                  aux   <= '0;
                end else begin
                  state <= S_LOAD;
                end
              end else begin
                beat <= beat + BW'(1);
              end
            end
          S_POST:
            if (cyc_end) begin
              if (ok_s) begin
                aux <= '0;
                if (INIT_CLKS == 0) begin
                  state  <= S_DONE;
                  done_q <= 1'b1;
                end else begin
                  state <= S_INIT;
                end
              end else if (aux == 32'(CD_TIMEOUT_CLKS - 1)) begin
                state <= S_FAIL;
                eto_q <= 1'b1;
              end else begin
                aux <= aux + 32'd1;
              end
            end
          S_INIT:
            if (cyc_end) begin
              if (aux == 32'(INIT_CLKS - 1)) begin
                state  <= S_DONE;
                done_q <= 1'b1;
              end else begin
                aux <= aux + 32'd1;
              end
            end
          default: ;
        endcase
      end
    end
  end

  assign in_ready    = (state == S_LOAD);
  assign tgt_prog_n  = (state != S_PROG);
  assign tgt_clk     = clk_q;
  assign tgt_data    = data_q;
  assign busy        = !(state inside {S_IDLE, S_DONE, S_FAIL});
  assign done        = done_q;
  assign err_status  = est_q;
  assign err_timeout = eto_q;

endmodule

// File: rtl/ppcfg_host_chk.sv
`timescale 1ns/1ps
module ppcfg_host_chk #(
  parameter int DW   = 8,
  parameter int HALF = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err_status,
  input logic          err_timeout,
  input logic          in_ready,
  input logic          tgt_prog_n,
  input logic          tgt_clk,
  input logic [DW-1:0] tgt_data
);

  logic        prev_clk;
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      run      <= 32'd1;
    end else begin
      prev_clk <= tgt_clk;
      run      <= (tgt_clk != prev_clk) ? 32'd1 : run + 32'd1;
    end
  end

  AST_PROG_CLK_LOW:   assert property (@(posedge clk) disable iff (!rst_n) !tgt_prog_n |-> !tgt_clk); // R2
  AST_PHASE_MIN:      assert property (@(posedge clk) disable iff (!rst_n) (tgt_clk != prev_clk) |-> (run >= 32'(HALF))); // R5
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) tgt_clk |-> $stable(tgt_data)); // R6
  AST_READY_CLK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !tgt_clk); // R7
  AST_DONE_NO_ERR:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !(err_status || err_timeout)); // R8
  AST_IDLE_CLK_LOW:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !tgt_clk); // R9

endmodule

bind ppcfg_host ppcfg_host_chk #(.DW(DW), .HALF(DCLK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_status(err_status),
  .err_timeout(err_timeout), .in_ready(in_ready), .tgt_prog_n(tgt_prog_n),
  .tgt_clk(tgt_clk), .tgt_data(tgt_data)
);

// File: tb/tb_ppcfg_host.sv
`timescale 1ns/1ps
module tb_ppcfg_host;
  localparam int RATIO = 4;
  localparam int HALF  = 2;
  localparam int PLOW  = 10;
  localparam int S2C   = 6;
  localparam int P2C   = 40;
  localparam int STO   = 50;
  localparam int CDTO  = 20;
  localparam int INITC = 5;
  localparam int LAG   = 3;

  logic clk = 1'b0;
  logic rst_n, start, mon, in_valid, in_last;
  logic [7:0] in_data;
  logic in_ready, tgt_prog_n, tgt_clk, busy, done, err_status, err_timeout;
  logic [7:0] tgt_data;
  logic nst = 1'b1;
  logic cdok = 1'b0;

  always #10 clk = ~clk;

  ppcfg_host #(
    .CLK_MHZ(50), .DW(8), .RATIO(RATIO), .DCLK_HALF(HALF), .PROG_LOW_CYC(PLOW),
    .STAT2CLK_CYC(S2C), .PROG2CLK_CYC(P2C), .ST_TIMEOUT_CYC(STO),
    .CD_TIMEOUT_CLKS(CDTO), .INIT_CLKS(INITC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mon_status(mon), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready), .tgt_prog_n(tgt_prog_n),
    .tgt_clk(tgt_clk), .tgt_data(tgt_data), .tgt_stat_n(nst), .tgt_cfg_ok(cdok),
    .busy(busy), .done(done), .err_status(err_status), .err_timeout(err_timeout)
  );

  int checks = 0, fails = 0;
  int cfg_len = 1, drop_at = 0;
  bit hold_low = 1'b0, cd_never = 1'b0;

  int cyc = 0, lowc = 0, relc = 0, edges = 0, pcd = 0, nlow = 0;
  int t_pr = -1, t_sr = -1, t_fr = -1, minhi = 1000, minlo = 1000, run = 0, ready_bad = 0;
  logic pd = 1'b0, pp = 1'b1, faulted = 1'b0;
  logic [7:0] cap [64];

  // target model and monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (start && !busy) begin
      edges = 0; pcd = 0; nlow = 0; t_pr = -1; t_sr = -1; t_fr = -1;
      minhi = 1000; minlo = 1000; run = 0; ready_bad = 0;
    end
    if (!tgt_prog_n) begin
      nlow++; lowc++; relc = 0; faulted = 1'b0;
      if (lowc == 3) begin nst = 1'b0; cdok = 1'b0; end
    end else begin
      lowc = 0;
      if (!pp) t_pr = cyc;
      if (!nst && !faulted && !hold_low && nlow > 0) begin
        relc++;
        if (relc == 4) begin nst = 1'b1; t_sr = cyc; end
      end
    end
    if (tgt_clk && !pd) begin
      if (t_fr < 0) t_fr = cyc;
      else if (run < minlo) minlo = run;
      if (edges < 64) cap[edges] = tgt_data;
      if (cdok) pcd++;
      edges++;
      if (!cd_never && edges == cfg_len * RATIO + LAG) cdok = 1'b1;
      if (drop_at > 0 && edges == drop_at) begin nst = 1'b0; faulted = 1'b1; end
      run = 1;
    end else if (!tgt_clk && pd) begin
      if (run < minhi) minhi = run;
      run = 1;
    end else begin
      run++;
    end
    if (in_ready && tgt_clk) ready_bad++;
    pd = tgt_clk;
    pp = tgt_prog_n;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] word_of(int len, int i);
    return 8'((i * 37 + len * 11 + 5) & 255);
  endfunction

  task automatic run_job(int len, bit m, int drop, bit hold, bit cdn, bit restrike, output int hs);
    int idx, gapc, guard;
    bit pend, struck;
    cfg_len = len; drop_at = drop; hold_low = hold; cd_never = cdn; mon = m;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    idx = 0; gapc = 0; guard = 0; hs = 0; pend = 1'b0; struck = 1'b0;
    while (!(done || err_status || err_timeout) && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      if (pend) begin idx++; hs++; pend = 1'b0; end
      if (restrike && !struck && idx == 1) begin start = 1'b1; struck = 1'b1; end
      else start = 1'b0;
      gapc++;
      in_valid = (idx < len) && (gapc % 3 != 1);
      in_data  = word_of(len, idx);
      in_last  = (idx == len - 1);
      pend     = in_valid && in_ready;
    end
    in_valid = 1'b0; start = 1'b0;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic check_ok(int len, bit m, int hs, string tag);
    int mism, e0;
    mism = 0;
    for (int i = 0; i < len * RATIO; i++)
      if (cap[i] !== word_of(len, i / RATIO)) mism++;
    check(nlow == PLOW, "R2 program pulse width", nlow, PLOW);
    if (m) check(t_fr - t_sr >= S2C, "R3 status-to-clock gap", t_fr - t_sr, S2C);
    else   check(t_fr - t_pr >= P2C, "R4 program-to-clock gap", t_fr - t_pr, P2C);
    check(minhi >= HALF && minlo >= HALF, "R5 min phase", (minhi < minlo) ? minhi : minlo, HALF);
    check(mism == 0, {"R6 word sequence ", tag}, mism, 0);
    check(hs == len, "R7 handshakes", hs, len);
    check(ready_bad == 0, "R7 ready while clock high", ready_bad, 0);
    check(done && !err_status && !err_timeout, {"R8 done flags ", tag}, {done, err_status, err_timeout}, 3'b100);
    check(pcd >= INITC && pcd <= INITC + 2, "R8 init clocks", pcd, INITC);
    e0 = edges;
    repeat (10) @(posedge clk);
    #1;
    check(edges == e0 && !tgt_clk, "R8 clock stopped", edges, e0);
  endtask

  initial begin
    int hs;
    rst_n = 1'b0; start = 1'b0; mon = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(tgt_prog_n && !tgt_clk && !in_ready && !busy && !done && !err_status && !err_timeout,
          "R1 reset state", {tgt_prog_n, tgt_clk, in_ready, busy, done, err_status, err_timeout}, 7'b1000000);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int len = 1; len <= 6; len++) begin
      run_job(len, 1'b1, 0, 1'b0, 1'b0, len == 3, hs);
      check_ok(len, 1'b1, hs, (len == 3) ? "R12 restart ignored" : "monitored");
    end

    for (int len = 1; len <= 3; len++) begin
      run_job(len, 1'b0, 3, 1'b0, 1'b0, 1'b0, hs);
      check(done && !err_status, "R11 status drop ignored", {done, err_status}, 2'b10);
      check_ok(len, 1'b0, hs, "unmonitored");
    end

    run_job(2, 1'b1, 0, 1'b0, 1'b1, 1'b0, hs);
    check(err_timeout && !done && !err_status, "R9 timeout flags", {err_timeout, done, err_status}, 3'b100);
    check(edges == 2 * RATIO + CDTO, "R9 edges before timeout", edges, 2 * RATIO + CDTO);
    check(tgt_prog_n && !tgt_clk && !busy, "R9 idle outputs", {tgt_prog_n, tgt_clk, busy}, 3'b100);

    run_job(4, 1'b1, 5, 1'b0, 1'b0, 1'b0, hs);
    check(err_status && !done && !err_timeout, "R10 status fault flags", {err_status, done, err_timeout}, 3'b100);
    check(edges == 5, "R10 no edge after fault", edges, 5);
    check(!tgt_clk && !in_ready, "R10 clock and ready low", {tgt_clk, in_ready}, 0);

    run_job(2, 1'b1, 0, 1'b1, 1'b0, 1'b0, hs);
    check(err_status && !done, "R13 release timeout flag", {err_status, done}, 2'b10);
    check(edges == 0, "R13 no clock edges", edges, 0);

    run_job(2, 1'b1, 0, 1'b0, 1'b0, 1'b0, hs);
    check(!err_status && !err_timeout, "R12 flags cleared on restart", {err_status, err_timeout}, 0);
    check_ok(2, 1'b1, hs, "after error");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

endmodule